// File: doc/BRIEF.md
# Chip-Select Output Controller

This block owns a small bank of output pins (eight by default) that a serial engine and software share. Every pin is backed by a one-bit output latch. A force write changes any chosen subset of latches in a single bus write: each pin has its own set bit and its own clear bit, so there is no read-modify-write and no risk of disturbing pins that another agent owns. A configuration word decides, for each pin on its own, whether the pin inverts its latch and whether it acts as a chip select.

A pin in chip-select mode is gated by the engine's transfer-active input. While no transfer runs, the pin is held at its deselected level. While a transfer runs, it follows its latch. A latch value of 0 always means "selected". The inversion bit picks the electrical polarity: with no inversion the select is active-low, and with inversion it is active-high. A plain pin (chip-select mode off) drives its latch, optionally inverted, and ignores the transfer signal.

Register writes arrive on a valid/ready write channel. The block accepts one write on every cycle in which `wr_valid` is high; `wr_ready` never drops after reset, so the channel applies no back-pressure. A write with `wr_valid` low has no effect whatever the other write pins carry. Software reads back the latch contents on a plain status port.

Top module: `cs_gpo_ctrl`

## Requirements
- R1: After reset the configuration word is 0, every latch holds 1, `pin_o` is 8'hFF and `latch_status` is 8'hFF.
- R2: In a force write (`wr_sel`=1), `wr_data` bit n clears latch n and bit 8+n sets latch n; latches whose two bits are both 0 keep their value.
- R3: A force write with both the set bit (8+n) and the clear bit (n) at 1 for a pin leaves that pin's latch unchanged.
- R4: A force write of 16'hFF00 drives all eight latches to 1.
- R5: In a configuration write (`wr_sel`=0), `wr_data` bit n is the inversion bit of pin n; a plain pin drives latch n XOR inversion bit n.
- R6: Configuration bit 8+n puts pin n in chip-select mode: while `xfer_active` is 0 the pin drives 1 XOR its inversion bit (deselected); while `xfer_active` is 1 it drives latch n XOR its inversion bit.
- R7: `latch_status` bits 7:0 always equal the eight latch values, independent of inversion and chip-select mode.
- R8: `latch_status` shows an accepted force write right after the clock edge that accepts it; `pin_o` reflects a latch, configuration or `xfer_active` change after the next clock edge (one register stage).
- R9: `wr_ready` is 1 whenever reset is released, and a cycle with `wr_valid` at 0 changes neither the latches nor the configuration.
- R10: A configuration write replaces the whole configuration word and leaves the latches untouched; a force write leaves the configuration untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request on the register channel |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| wr_sel | input | 1 | Target register: 0 configuration, 1 force |
| wr_data | input | 16 | Write data; field layout per R2, R5, R6 |
| xfer_active | input | 1 | High while the serial engine runs a transfer |
| pin_o | output | 8 | Registered pin levels |
| latch_status | output | 8 | Current output latch values |

## Verification
The hardest case to reach is a pin in chip-select mode with inversion on, where the gating, the inversion and a conflicting set-and-clear write all act on one pin. If any of them is applied in the wrong order, the pin lands on the mirrored level. The stimulus builds up to this case. It first clears latches selectively and issues same-pin set/clear conflicts on plain pins. It then switches two pins to chip-select mode, one of them inverted, and toggles `xfer_active` around force writes. Every step is compared against a bit-level model of the latch and pin equations. Separate cycle-exact probes confirm that `latch_status` moves one edge before `pin_o`.

// File: rtl/cs_gpo_pkg.sv
package cs_gpo_pkg;

  // Register targets on the write channel.
  typedef enum logic {
    SEL_CONFIG = 1'b0,
    SEL_FORCE  = 1'b1
  } cs_gpo_sel_e;

  // Deselected pin level for a chip-select pin: latch treated as 1.
  function automatic logic idle_level(input logic inv);
    return 1'b1 ^ inv;
  endfunction

endpackage

// File: rtl/cs_gpo_regs.sv
module cs_gpo_regs
  import cs_gpo_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int DW   = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [NPINS-1:0] cfg_inv,
  output logic [NPINS-1:0] cfg_cs,
  output logic [NPINS-1:0] set_mask,
  output logic [NPINS-1:0] clr_mask
);

  cs_gpo_sel_e sel;
  logic        cfg_hit;
  logic        force_hit;
  logic [DW-1:0] cfg_q;

  assign sel       = cs_gpo_sel_e'(wr_sel);
  assign cfg_hit   = wr_valid && (sel == SEL_CONFIG);
  assign force_hit = wr_valid && (sel == SEL_FORCE);

  // Upper half sets, lower half clears.
  assign set_mask = force_hit ? wr_data[DW-1:NPINS] : '0;
  assign clr_mask = force_hit ? wr_data[NPINS-1:0]  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (cfg_hit) cfg_q <= wr_data;
  end

  assign cfg_inv = cfg_q[NPINS-1:0];
  assign cfg_cs  = cfg_q[DW-1:NPINS];

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && !wr_sel) |=> $stable(cfg_q));

  // R9
  idle_no_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (set_mask == '0 && clr_mask == '0));

endmodule

// File: rtl/cs_gpo_latch.sv
module cs_gpo_latch #(
  parameter int              NPINS     = 8,
  parameter logic [NPINS-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_mask,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] latch_q
);

  for (genvar n = 0; n < NPINS; n++) begin : g_bit
    logic do_set;
    logic do_clr;

    // A conflicting pair cancels out.
    assign do_set = set_mask[n] && !clr_mask[n];
    assign do_clr = clr_mask[n] && !set_mask[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q[n] <= RESET_VAL[n];
      else if (do_set) latch_q[n] <= 1'b1;
      else if (do_clr) latch_q[n] <= 1'b0;
    end

    // R3
    conflict_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask[n] && clr_mask[n]) |=> $stable(latch_q[n]));

    // R2
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[n] && !set_mask[n]) |=> !latch_q[n]);

    // R2
    set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask[n] && !clr_mask[n]) |=> latch_q[n]);

    // R9
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_mask[n] || clr_mask[n]) |=> $stable(latch_q[n]));
  end

endmodule

// File: rtl/cs_gpo_drive.sv
module cs_gpo_drive
  import cs_gpo_pkg::*;
#(
  parameter int               NPINS     = 8,
  parameter logic [NPINS-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] latch_q,
  input  logic [NPINS-1:0] cfg_inv,
  input  logic [NPINS-1:0] cfg_cs,
  input  logic             xfer_active,
  output logic [NPINS-1:0] pin_q
);

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic level_d;

    always_comb begin
      if (cfg_cs[n] && !xfer_active) level_d = idle_level(cfg_inv[n]);
      else                            level_d = latch_q[n] ^ cfg_inv[n];
    end

    // Configuration resets to zero, so the pin starts at the latch value.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q[n] <= RESET_VAL[n];
      else        pin_q[n] <= level_d;
    end

    // R6
    gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cs[n] && !xfer_active) |=> (pin_q[n] == !$past(cfg_inv[n])));

    // R5
    plain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_cs[n] |=> (pin_q[n] == ($past(latch_q[n]) ^ $past(cfg_inv[n]))));
  end

endmodule

// File: rtl/cs_gpo_ctrl.sv
module cs_gpo_ctrl
  import cs_gpo_pkg::*;
#(
  parameter int               NPINS     = 8,
  parameter logic [NPINS-1:0] RESET_VAL = '1,
  localparam int              DW        = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             xfer_active,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] latch_status
);

  logic [NPINS-1:0] cfg_inv;
  logic [NPINS-1:0] cfg_cs;
  logic [NPINS-1:0] set_mask;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] latch_q;

  // Writes complete in one cycle: no back-pressure.
  assign wr_ready = 1'b1;

  cs_gpo_regs #(.NPINS(NPINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cfg_inv  (cfg_inv),
    .cfg_cs   (cfg_cs),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  cs_gpo_latch #(.NPINS(NPINS), .RESET_VAL(RESET_VAL)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .latch_q  (latch_q)
  );

  cs_gpo_drive #(.NPINS(NPINS), .RESET_VAL(RESET_VAL)) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_q     (latch_q),
    .cfg_inv     (cfg_inv),
    .cfg_cs      (cfg_cs),
    .xfer_active (xfer_active),
    .pin_q       (pin_o)
  );

  assign latch_status = latch_q;

  // R7
  status_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid) |=> $stable(latch_status));

  // R4
  all_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel && wr_data == {{NPINS{1'b1}}, {NPINS{1'b0}}})
      |=> (latch_status == '1));

endmodule

// File: tb/tb_cs_gpo_ctrl.sv
`timescale 1ns/1ps
module tb_cs_gpo_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        xfer_active = 1'b0;
  logic [7:0]  pin_o;
  logic [7:0]  latch_status;

  int checks = 0;
  int fails  = 0;

  // Reference state
  logic [15:0] cfg_m   = '0;
  logic [7:0]  latch_m = 8'hFF;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cs_gpo_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .xfer_active(xfer_active),
    .pin_o(pin_o), .latch_status(latch_status)
  );

  function automatic logic [7:0] model_pins(input logic [7:0] lat,
                                            input logic [15:0] cfg,
                                            input logic busy);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      if (cfg[8+i]) p[i] = (lat[i] | ~busy) ^ cfg[i];
      else          p[i] = lat[i] ^ cfg[i];
    end
    return p;
  endfunction

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Driver side
  task automatic do_write(input logic sel, input logic [15:0] data);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = sel;
    wr_data  = data;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = 16'hDEAD;
    if (sel) begin
      for (int i = 0; i < 8; i++)
        if (data[8+i] && !data[i])      latch_m[i] = 1'b1;
        else if (data[i] && !data[8+i]) latch_m[i] = 1'b0;
    end else begin
      cfg_m = data;
    end
  endtask

  task automatic expect_now(input string tag);
    @(posedge clk);
    @(posedge clk);
    #1;
    exp_q.push_back({model_pins(latch_m, cfg_m, xfer_active), latch_m});
    tag_q.push_back(tag);
  endtask

  // Monitor side
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {pin_o, latch_status}, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset pins/status", {pin_o, latch_status}, 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", {15'd0, wr_ready}, 16'd1);
    expect_now("R1 reset steady");

    // R2 selective clears, then sets
    do_write(1'b1, 16'h00A5);
    expect_now("R2 clear pins 0,2,5,7");
    do_write(1'b1, 16'h0300);
    expect_now("R2 set pins 0,1");

    // R3 conflicting bits on a high and a low latch
    do_write(1'b1, 16'h0101);
    expect_now("R3 conflict pin0 stays 1");
    do_write(1'b1, 16'h8080);
    expect_now("R3 conflict pin7 stays 0");

    // R8 latency: status first, pins one edge later
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 1'b1; wr_data = 16'h00FF;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R8 status after accept edge", {8'd0, latch_status}, 16'h0000);
    check("R8 pins still old", {8'd0, pin_o}, {8'd0, latch_m});
    latch_m = 8'h00;
    @(negedge clk);
    check("R8 pins after second edge", {8'd0, pin_o}, 16'h0000);

    // R4 all high
    do_write(1'b1, 16'hFF00);
    expect_now("R4 FF00 sets all");

    // R5 / R7 / R10 inversion on low nibble
    do_write(1'b0, 16'h000F);
    expect_now("R5 R7 R10 invert low nibble");
    do_write(1'b1, 16'h0030);
    expect_now("R5 clear pins 4,5 with inversion");

    // R6 chip-select mode on pins 0 (active-low) and 1 (active-high)
    do_write(1'b0, 16'h0302);
    expect_now("R6 R10 cs mode idle");
    do_write(1'b1, 16'h0003);
    expect_now("R6 selected latch but idle");
    @(negedge clk);
    xfer_active = 1'b1;
    @(negedge clk);
    check("R8 R6 pins after busy edge", {8'd0, pin_o},
          {8'd0, model_pins(latch_m, cfg_m, 1'b1)});
    expect_now("R6 transfer active selects");
    do_write(1'b1, 16'h0303);
    expect_now("R3 R6 conflict during transfer");
    do_write(1'b1, 16'h0100);
    expect_now("R6 deselect pin0 in transfer");
    @(negedge clk);
    xfer_active = 1'b0;
    expect_now("R6 transfer ends idles");

    // R9 data on bus with valid low
    @(negedge clk);
    wr_sel = 1'b1; wr_data = 16'h00FF;
    repeat (2) @(negedge clk);
    wr_sel = 1'b0; wr_data = 16'hFFFF;
    repeat (2) @(negedge clk);
    expect_now("R9 valid low ignored");

    // R10 config rewrite leaves latches; plain pins again
    do_write(1'b0, 16'h0000);
    expect_now("R10 R7 config clear keeps latches");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    report();
  end

endmodule